// File: doc/BRIEF.md
# Multi-Chain Configuration Table Expander

This block sits behind a variable-length symbol decoder in a reconfigurable fabric. Each cycle the decoder may hand over several symbols at once. A symbol is either a short index into a fixed table of commonly used logic-block configurations or a full-width configuration word that is not in the table. The block expands every symbol into its complete configuration word. It reads all indexed entries of one group in the same cycle, using one table read port per lane. Each word then goes to its own serial configuration chain.

Successive symbols go to successive chains under a rotating pointer. Decoding several symbols per cycle therefore fills several chains side by side instead of queueing behind one serial path. A chain shifts its word out least significant bit first and flags completion. When any chain that the offered group would occupy is still working, the block withholds its ready signal until that chain is free.

Top module: `cfgx_expander`

## Requirements
- R1: After synchronous reset every chain is idle: `chain_en` and `chain_done` are all low, `in_ready` is high, and the rotation pointer selects chain 0.
- R2: A symbol with its raw flag low delivers table entry `idx`. Entry i of the default table is the low 16 bits of (i * 0x1357) XOR 0xA5C3.
- R3: A symbol with its raw flag high delivers its own `in_word` slice unchanged, and the table is not consulted.
- R4: A chain that received a word in the group accepted at clock edge a holds `chain_en` high for exactly CFG_W consecutive cycles, starting after edge a+2. Bit k of the word appears on `chain_bit` in the k-th of those cycles, counting from 0 (least significant bit first).
- R5: Lane k of an accepted group (lanes are numbered from 0 in the packed input vectors) goes to chain (p + k) mod LANES, where p is the rotation pointer. After the group the pointer becomes (p + in_cnt) mod LANES.
- R6: A group is accepted on any clock edge where `in_cnt` is non-zero and `in_ready` is high. Up to LANES symbols can be accepted on one edge, and lanes at or above `in_cnt` have no effect on any chain.
- R7: `in_ready` is low exactly when one of the chains (p + k) mod LANES, for k below `in_cnt`, is busy. A chain is busy from the edge that accepts its word until its last bit has been shown. While `in_ready` is low nothing is accepted and the pointer holds.
- R8: In the cycle after a chain shows its last bit, its `chain_done` is high for exactly one cycle, and `chain_en` is low in that cycle.
- R9: When `in_cnt` is zero nothing is accepted, every chain continues undisturbed, and the pointer does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_cnt | input | CNT_W | Number of valid symbols in lanes 0..in_cnt-1 |
| in_raw | input | LANES | Per-lane flag: 1 = raw word, 0 = table index |
| in_idx | input | LANES*IDX_W | Per-lane table index, lane k at bits k*IDX_W upward |
| in_word | input | LANES*CFG_W | Per-lane raw word, lane k at bits k*CFG_W upward |
| in_ready | output | 1 | Group offered this cycle can be accepted |
| chain_bit | output | LANES | Serial configuration bit per chain |
| chain_en | output | LANES | Shift enable per chain, high while a bit is valid |
| chain_done | output | LANES | One-cycle completion pulse per chain |

## Verification
The bench offers groups continuously while chains are still shifting. A design that looked only at the chain at the pointer, or that ignored the one-cycle table stage, would accept a group into an occupied chain, and the words of the two groups would interleave on `chain_bit`. Pointer wrap-around is exercised with group sizes that do not divide the chain count. A wrong modulo or a pointer that moves by one per group would put words on the wrong chains. Unused lanes and idle cycles carry random junk, so a design that decoded lanes beyond `in_cnt`, or that moved the pointer on an empty group, would start spurious chains. Raw and indexed symbols are mixed inside one group, which catches a bypass mux that selects per group instead of per lane.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

    localparam int DEF_LANES = 4;
    localparam int DEF_CFG_W = 16;
    localparam int DEF_DEPTH = 8;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_SHIFT = 2'd1,
        CH_DONE  = 2'd2
    } chain_st_e;

    // Default contents of the frequent-configuration table.
    function automatic logic [DEF_DEPTH*DEF_CFG_W-1:0] mk_table();
        logic [DEF_DEPTH*DEF_CFG_W-1:0] r;
        logic [31:0] t;
        r = '0;
        for (int i = 0; i < DEF_DEPTH; i++) begin
            t = (32'(i) * 32'h1357) ^ 32'h0000_A5C3;
            r[i*DEF_CFG_W +: DEF_CFG_W] = t[DEF_CFG_W-1:0];
        end
        return r;
    endfunction

    function automatic int unsigned wrap_add(int unsigned a, int unsigned b, int unsigned n);
        return (a + b) % n;
    endfunction

endpackage

// File: rtl/cfgx_tbl_port.sv
module cfgx_tbl_port #(
    parameter int CFG_W = 16,
    parameter int DEPTH = 8,
    parameter int IDX_W = 3,
    parameter logic [DEPTH*CFG_W-1:0] TBL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_en,
    input  logic             rd_raw,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [CFG_W-1:0] rd_word,
    output logic             out_vld,
    output logic [CFG_W-1:0] out_word
);
    logic [CFG_W-1:0] tbl_word;

    always_comb begin
        tbl_word = '0;
        if (int'(rd_idx) < DEPTH)
            tbl_word = TBL[int'(rd_idx)*CFG_W +: CFG_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld  <= 1'b0;
            out_word <= '0;
        end else begin
            out_vld <= rd_en;
            if (rd_en)
                out_word <= rd_raw ? rd_word : tbl_word;
        end
    end
endmodule

// File: rtl/cfgx_chain.sv
module cfgx_chain
    import cfgx_pkg::*;
#(
    parameter int CFG_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_vld,
    input  logic [CFG_W-1:0] ld_word,
    output logic             sdo,
    output logic             sen,
    output logic             done,
    output logic             busy
);
    localparam int CW = $clog2(CFG_W + 1);

    chain_st_e        st;
    logic [CFG_W-1:0] sreg;
    logic [CW-1:0]    left;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= CH_IDLE;
            sreg <= '0;
            left <= '0;
        end else if (ld_vld) begin
            st   <= CH_SHIFT;
            sreg <= ld_word;
            left <= CW'(CFG_W);
        end else begin
            case (st)
                CH_SHIFT: begin
                    sreg <= sreg >> 1;
                    left <= left - 1'b1;
                    if (left == CW'(1))
                        st <= CH_DONE;
                end
                CH_DONE:  st <= CH_IDLE;
                default:  st <= CH_IDLE;
            endcase
        end
    end

    assign sdo  = sreg[0];
    assign sen  = (st == CH_SHIFT);
    assign done = (st == CH_DONE);
    assign busy = (st == CH_SHIFT);
endmodule

// File: rtl/cfgx_expander.sv
module cfgx_expander
    import cfgx_pkg::*;
#(
    parameter int LANES = DEF_LANES,
    parameter int CFG_W = DEF_CFG_W,
    parameter int DEPTH = DEF_DEPTH,
    parameter int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int CNT_W = $clog2(LANES + 1),
    parameter logic [DEPTH*CFG_W-1:0] TBL = mk_table()
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [CNT_W-1:0]       in_cnt,
    input  logic [LANES-1:0]       in_raw,
    input  logic [LANES*IDX_W-1:0] in_idx,
    input  logic [LANES*CFG_W-1:0] in_word,
    output logic                   in_ready,
    output logic [LANES-1:0]       chain_bit,
    output logic [LANES-1:0]       chain_en,
    output logic [LANES-1:0]       chain_done
);
    localparam int PW = (LANES > 1) ? $clog2(LANES) : 1;

    logic [PW-1:0]    rr_ptr;
    logic [CNT_W-1:0] eff_cnt;
    logic             accept;
    logic [LANES-1:0] pend;
    logic [LANES-1:0] shifting;
    logic [LANES-1:0] busy;

    logic [LANES-1:0] sel_en;
    logic [LANES-1:0] sel_raw;
    logic [IDX_W-1:0] sel_idx  [LANES];
    logic [CFG_W-1:0] sel_word [LANES];
    logic [CFG_W-1:0] stg_word [LANES];

    always_comb begin
        eff_cnt = in_cnt;
        if (int'(in_cnt) > LANES)
            eff_cnt = CNT_W'(LANES);
    end

    assign busy = pend | shifting;

    always_comb begin
        in_ready = 1'b1;
        for (int k = 0; k < LANES; k++) begin
            if (k < int'(eff_cnt) && busy[wrap_add(int'(rr_ptr), k, LANES)])
                in_ready = 1'b0;
        end
    end

    assign accept = (eff_cnt != '0) && in_ready;

    // Lane-to-chain steering: chain c takes lane (c - ptr) mod LANES.
    always_comb begin
        for (int c = 0; c < LANES; c++) begin
            automatic int lane = int'(wrap_add(c, LANES - int'(rr_ptr), LANES));
            sel_en[c]   = 1'b0;
            sel_raw[c]  = 1'b0;
            sel_idx[c]  = '0;
            sel_word[c] = '0;
            if (accept && lane < int'(eff_cnt)) begin
                sel_en[c]   = 1'b1;
                sel_raw[c]  = in_raw[lane];
                sel_idx[c]  = in_idx[lane*IDX_W +: IDX_W];
                sel_word[c] = in_word[lane*CFG_W +: CFG_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rr_ptr <= '0;
        else if (accept)
            rr_ptr <= PW'(wrap_add(int'(rr_ptr), int'(eff_cnt), LANES));
    end

    for (genvar c = 0; c < LANES; c++) begin : g_chain
        cfgx_tbl_port #(
            .CFG_W(CFG_W), .DEPTH(DEPTH), .IDX_W(IDX_W), .TBL(TBL)
        ) u_port (
            .clk(clk), .rst(rst),
            .rd_en(sel_en[c]), .rd_raw(sel_raw[c]),
            .rd_idx(sel_idx[c]), .rd_word(sel_word[c]),
            .out_vld(pend[c]), .out_word(stg_word[c])
        );

        cfgx_chain #(.CFG_W(CFG_W)) u_chain (
            .clk(clk), .rst(rst),
            .ld_vld(pend[c]), .ld_word(stg_word[c]),
            .sdo(chain_bit[c]), .sen(chain_en[c]),
            .done(chain_done[c]), .busy(shifting[c])
        );
    end
endmodule

// File: rtl/cfgx_checker.sv
module cfgx_checker #(
    parameter int LANES = 4,
    parameter int CFG_W = 16,
    parameter int PW    = 2,
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] in_cnt,
    input logic             in_ready,
    input logic [LANES-1:0] chain_en,
    input logic [LANES-1:0] chain_done,
    input logic [PW-1:0]    rr_ptr
);
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (chain_en == '0 && chain_done == '0 && rr_ptr == '0 && in_ready));

    p_ptr_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !(in_cnt != '0 && in_ready) |=> $stable(rr_ptr));

    p_busy_blocks_r7: assert property (@(posedge clk) disable iff (rst)
        (in_cnt != '0 && chain_en[rr_ptr]) |-> !in_ready);

    for (genvar c = 0; c < LANES; c++) begin : g_chk
        int unsigned run;

        always_ff @(posedge clk) begin
            if (rst)               run <= 0;
            else if (chain_en[c])  run <= run + 1;
            else                   run <= 0;
        end

        p_run_cap_r4: assert property (@(posedge clk) disable iff (rst)
            chain_en[c] |-> (run < CFG_W));

        p_run_len_r4: assert property (@(posedge clk) disable iff (rst)
            $fell(chain_en[c]) |-> (run == CFG_W));

        p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
            chain_done[c] |-> (!chain_en[c] && $past(chain_en[c])));

        p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
            chain_done[c] |=> !chain_done[c]);
    end
endmodule

bind cfgx_expander cfgx_checker #(
    .LANES(LANES), .CFG_W(CFG_W), .PW(PW), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst(rst), .in_cnt(in_cnt), .in_ready(in_ready),
    .chain_en(chain_en), .chain_done(chain_done), .rr_ptr(rr_ptr)
);

// File: tb/sim_cfgx_expander.sv
`timescale 1ns/1ps
module sim_cfgx_expander;
    localparam int LANES = 4;
    localparam int CFG_W = 16;
    localparam int DEPTH = 8;
    localparam int IDX_W = 3;
    localparam int CNT_W = 3;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic [CNT_W-1:0]       in_cnt = '0;
    logic [LANES-1:0]       in_raw = '0;
    logic [LANES*IDX_W-1:0] in_idx = '0;
    logic [LANES*CFG_W-1:0] in_word = '0;
    logic                   in_ready;
    logic [LANES-1:0]       chain_bit, chain_en, chain_done;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    cfgx_expander u0 (
        .clk(clk), .rst(rst), .in_cnt(in_cnt), .in_raw(in_raw),
        .in_idx(in_idx), .in_word(in_word), .in_ready(in_ready),
        .chain_bit(chain_bit), .chain_en(chain_en), .chain_done(chain_done)
    );

    // Behavioural reference: per chain, the edge of its latest acceptance and its word.
    int          job_a [LANES];
    logic [15:0] job_w [LANES];
    string       job_t [LANES];
    int          ptr_m = 0;
    int          cyc   = 0;
    string       ptag  = "R1";

    function automatic logic [15:0] ref_tbl(int i);
        logic [31:0] t;
        t = i * 32'h1357;
        return t[15:0] ^ 16'hA5C3;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s cyc=%0d actual=%0d expected=%0d", tag, cyc, act, exp);
        end
    endtask

    task automatic drive(int mode);
        int n;
        in_raw  = LANES'($urandom);
        in_idx  = {$urandom, $urandom};
        in_word = {$urandom, $urandom};
        case (mode)
            0: n = ($urandom % 2) ? 1 : 0;                // single indexed
            1: begin n = ($urandom % 2) ? 1 : 0; in_raw = '1; end
            2: n = LANES;                                // full groups
            3: n = $urandom % (LANES + 1);               // mixed sizes, junk lanes
            4: n = 0;                                    // idle with junk
            default: n = 3;                              // non-dividing size
        endcase
        if (mode == 0) in_raw = '0;
        in_cnt = CNT_W'(n);
    endtask

    task automatic step(int mode);
        bit acc;
        bit exp_rdy;
        int n;
        @(negedge clk);
        drive(mode);
        #1;
        for (int c = 0; c < LANES; c++) begin
            automatic int  a  = job_a[c];
            automatic bit  en = (cyc >= a + 2) && (cyc <= a + CFG_W + 1);
            automatic bit  dn = (cyc == a + CFG_W + 2);
            chk(chain_en[c] == en, {ptag, " R4 R5 en"}, chain_en[c], en);
            chk(chain_done[c] == dn, {ptag, " R8 done"}, chain_done[c], dn);
            if (en)
                chk(chain_bit[c] == job_w[c][cyc - a - 2], {ptag, " ", job_t[c], " bit"},
                    chain_bit[c], job_w[c][cyc - a - 2]);
        end
        n = int'(in_cnt);
        exp_rdy = 1'b1;
        for (int k = 0; k < n; k++) begin
            automatic int c = (ptr_m + k) % LANES;
            if (cyc >= job_a[c] && cyc <= job_a[c] + CFG_W + 1) exp_rdy = 1'b0;
        end
        chk(in_ready == exp_rdy, {ptag, " R7 ready"}, in_ready, exp_rdy);
        acc = (n > 0) && exp_rdy;
        @(posedge clk);
        cyc++;
        if (acc) begin
            for (int k = 0; k < n; k++) begin
                automatic int c = (ptr_m + k) % LANES;
                job_a[c] = cyc - 1;
                job_w[c] = in_raw[k] ? in_word[k*CFG_W +: CFG_W]
                                     : ref_tbl(int'(in_idx[k*IDX_W +: IDX_W]));
                job_t[c] = in_raw[k] ? "R3" : "R2";
            end
            ptr_m = (ptr_m + n) % LANES;
        end
    endtask

    initial begin
        for (int c = 0; c < LANES; c++) begin
            job_a[c] = -1000;
            job_w[c] = '0;
            job_t[c] = "R2";
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(chain_en == '0, "R1 en after reset", chain_en, 0);
        chk(chain_done == '0, "R1 done after reset", chain_done, 0);
        chk(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
        // First full group must land on chains 0..3 in lane order (pointer at 0).
        ptag = "R1 R5";   repeat (40)  step(2);
        ptag = "R2";      repeat (300) step(0);
        ptag = "R3";      repeat (300) step(1);
        ptag = "R5";      repeat (300) step(5);
        ptag = "R6";      repeat (600) step(3);
        ptag = "R9";      repeat (60)  step(4);
        ptag = "R7";      repeat (300) step(2);
        ptag = "R6";      repeat (400) step(3);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired cyc=%0d actual=0 expected=1", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule